// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable model of the device side of a three-wire serial EEPROM that holds 128 bytes. It watches a chip-select, a serial clock and a data-in pin, all three brought into the system clock domain. It recognises the start of an instruction and collects an opcode, an address and, where needed, a data byte. It then performs a byte read, a byte write, a byte erase, a whole-array erase, a whole-array write, or one of the two commands that unlock or relock programming. The serial output comes out as a data bit and an output-enable, so a pad or a bench can form the tri-state pin.

Programming is self-timed. When chip-select falls after a complete program instruction, a counter of `PROG_CYCLES` system clocks stands in for the long nonvolatile write time. While chip-select is high, the output shows whether that cycle is still running. Reads stream without limit: while chip-select stays high the address keeps advancing, wrapping at the top of the array. A host controller or a board-level testbench can talk to this model as if it were the real memory.

Top module: `mw_eeprom_model`

## Requirements
- R1: An instruction begins only at the first synchronised serial-clock rise that finds chip-select high and data-in high while the device is idle; earlier rises with data-in low are ignored.
- R2: After the start bit the device takes a 2-bit opcode and then 7 address bits, most significant first; opcode 10 is read, 01 is write, 11 is erase.
- R3: With opcode 00 the top two address bits select the command (11 unlock, 00 lock, 10 erase all, 01 write all) and the other five bits are don't-care.
- R4: An instruction whose bits are not all received before chip-select falls has no effect: memory is unchanged and no busy/ready status appears.
- R5: After reset every byte reads 0xFF, the output-enable is low and programming is locked; write, erase, erase-all and write-all do nothing until unlock runs, and lock disables them again; read works in both states.
- R6: A read drives a 0 on the output, with output-enable high, after the last address bit; each following serial-clock rise puts out the next data bit, most significant first.
- R7: While chip-select stays high a read continues into the following bytes, and the address wraps from 127 to 0.
- R8: Write replaces the addressed byte with the 8 data bits that follow the address; erase sets the addressed byte to 0xFF.
- R9: Erase-all sets all 128 bytes to 0xFF; write-all sets all 128 bytes to its data byte.
- R10: A complete, unlocked program instruction starts a cycle of PROG_CYCLES system clocks when chip-select falls; with chip-select high the output is enabled and reads 0 while the cycle runs and 1 after it ends.
- R11: The output-enable is low whenever chip-select is low, and a start bit received after the cycle has ended removes the ready status, so the output-enable goes low.
- R12: Any instruction sent while a program cycle runs is ignored and does not affect memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip-select pin, asynchronous |
| sclk_i | input | 1 | Serial clock pin, asynchronous |
| di_i | input | 1 | Serial data-in pin, asynchronous |
| do_o | output | 1 | Serial data-out value |
| do_oe_o | output | 1 | Data-out drive enable |

## Verification
Every address is written with an arithmetic pattern and then read back in one long stream that runs past the top of the array. This separates address decoding, bit order and the wrap of the address counter. Whole-array erase and write-all are followed by full reads, which show that every location changes and that the two commands are decoded apart from each other and from the byte commands. Locked writes, truncated frames, leading zero bits and a frame sent while busy are each followed by a read of the affected byte, so an ignored command is seen to leave the memory as it was. The busy, ready and cleared states of the output are sampled around every program cycle.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [2:0] {
        C_NONE, C_READ, C_WRITE, C_ERASE, C_ERAL, C_WRAL, C_EWEN, C_EWDS
    } cmd_e;

    typedef enum logic [1:0] {
        F_IDLE, F_SHIFT, F_READ, F_DONE
    } fstate_e;

    function automatic cmd_e decode_cmd(input logic [1:0] op, input logic [1:0] ext);
        cmd_e c;
        case (op)
            2'b10:   c = C_READ;
            2'b01:   c = C_WRITE;
            2'b11:   c = C_ERASE;
            default: begin
                case (ext)
                    2'b11:   c = C_EWEN;
                    2'b00:   c = C_EWDS;
                    2'b10:   c = C_ERAL;
                    default: c = C_WRAL;
                endcase
            end
        endcase
        return c;
    endfunction

    function automatic logic is_prog(input cmd_e c);
        return (c == C_WRITE) || (c == C_ERASE) || (c == C_ERAL) || (c == C_WRAL);
    endfunction

    function automatic logic has_data(input cmd_e c);
        return (c == C_WRITE) || (c == C_WRAL);
    endfunction

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
        end else begin
            pipe[0] <= pin_i;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    assign lvl_o = pipe[STAGES-1];
endmodule

// File: rtl/mw_frame.sv
module mw_frame
    import mw_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_i,
    input  logic              sclk_i,
    input  logic              di_i,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              start_o,
    output logic              commit_o,
    output cmd_e              cmd_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              reading_o,
    output logic              rd_bit_o
);
    localparam int HDR_W   = 2 + ADDR_W;
    localparam int FRAME_W = HDR_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int BIT_W   = $clog2(DATA_W);

    fstate_e            st;
    logic [HDR_W-2:0]   sr;
    logic [HDR_W-1:0]   shv;
    logic [CNT_W-1:0]   cnt;
    logic [BIT_W-1:0]   bidx;
    logic               sclk_q, cs_q, sclk_rise, cs_fall;
    cmd_e               dec;

    always_comb begin
        sclk_rise = sclk_i && !sclk_q;
        cs_fall   = !cs_i && cs_q;
        shv       = {sr, di_i};
        dec       = decode_cmd(shv[HDR_W-1 -: 2], shv[ADDR_W-1 -: 2]);
        start_o   = (st == F_IDLE) && cs_i && sclk_rise && di_i && !busy_i;
        commit_o  = cs_fall && (st == F_DONE);
        reading_o = (st == F_READ);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= F_IDLE; sr <= '0; cnt <= '0; bidx <= '0;
            sclk_q <= 1'b0; cs_q <= 1'b0;
            cmd_o <= C_NONE; addr_o <= '0; data_o <= '0;
            rd_addr_o <= '0; rd_bit_o <= 1'b0;
        end else begin
            sclk_q <= sclk_i;
            cs_q   <= cs_i;
            if (!cs_i) begin
                st  <= F_IDLE;
                cnt <= '0;
            end else if (sclk_rise) begin
                case (st)
                    F_IDLE: if (start_o) begin
                        st  <= F_SHIFT;
                        cnt <= '0;
                    end
                    F_SHIFT: begin
                        sr  <= shv[HDR_W-2:0];
                        cnt <= cnt + CNT_W'(1);
                        if (cnt == CNT_W'(HDR_W - 1)) begin
                            cmd_o  <= dec;
                            addr_o <= shv[ADDR_W-1:0];
                            if (dec == C_READ) begin
                                st        <= F_READ;
                                rd_addr_o <= shv[ADDR_W-1:0];
                                rd_bit_o  <= 1'b0;
                                bidx      <= '0;
                            end else if (!has_data(dec)) begin
                                st <= F_DONE;
                            end
                        end else if (cnt == CNT_W'(FRAME_W - 1)) begin
                            data_o <= shv[DATA_W-1:0];
                            st     <= F_DONE;
                        end
                    end
                    F_READ: begin
                        rd_bit_o <= rd_data_i[BIT_W'(DATA_W - 1) - bidx];
                        if (bidx == BIT_W'(DATA_W - 1)) begin
                            bidx      <= '0;
                            rd_addr_o <= rd_addr_o + ADDR_W'(1);
                        end else begin
                            bidx <= bidx + BIT_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/mw_store.sv
module mw_store
    import mw_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int PROG_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit_i,
    input  cmd_e              cmd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              busy_o,
    output logic              prog_start_o
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int TMR_W = $clog2(PROG_CYCLES + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic              wen_q, busy_q;
    logic [TMR_W-1:0]  tmr;
    cmd_e              p_cmd;
    logic [ADDR_W-1:0] p_addr;
    logic [DATA_W-1:0] p_data;

    always_comb begin
        prog_start_o = commit_i && wen_q && is_prog(cmd_i) && !busy_q;
        rd_data_o    = mem[rd_addr_i];
        busy_o       = busy_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wen_q <= 1'b0; busy_q <= 1'b0; tmr <= '0;
            p_cmd <= C_NONE; p_addr <= '0; p_data <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else begin
            if (commit_i && !busy_q) begin
                if (cmd_i == C_EWEN) wen_q <= 1'b1;
                if (cmd_i == C_EWDS) wen_q <= 1'b0;
            end
            if (prog_start_o) begin
                busy_q <= 1'b1;
                tmr    <= TMR_W'(PROG_CYCLES - 1);
                p_cmd  <= cmd_i;
                p_addr <= addr_i;
                p_data <= data_i;
            end else if (busy_q) begin
                if (tmr == '0) begin
                    busy_q <= 1'b0;
                    case (p_cmd)
                        C_ERASE: mem[p_addr] <= '1;
                        C_WRITE: mem[p_addr] <= p_data;
                        C_ERAL:  for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
                        C_WRAL:  for (int i = 0; i < DEPTH; i++) mem[i] <= p_data;
                        default: ;
                    endcase
                end else begin
                    tmr <= tmr - TMR_W'(1);
                end
            end
        end
    end

    // R12: the frame logic never completes an instruction while a cycle runs
    a_r12_commit_not_busy: assert property (@(posedge clk) disable iff (rst)
        commit_i |-> !busy_q);

    // R5: a program cycle only begins while unlocked
    a_r5_prog_needs_wen: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> $past(wen_q));

    // R10: a program cycle only begins on a completed frame at chip-select fall
    a_r10_busy_from_commit: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> $past(commit_i));
endmodule

// File: rtl/mw_eeprom_model.sv
module mw_eeprom_model
    import mw_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int PROG_CYCLES = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_i,
    input  logic sclk_i,
    input  logic di_i,
    output logic do_o,
    output logic do_oe_o
);
    logic [2:0]        pins_s;
    logic              cs_s, sclk_s, di_s;
    logic              start, commit, reading, rd_bit, busy, prog_start;
    cmd_e              cmd;
    logic [ADDR_W-1:0] addr, rd_addr;
    logic [DATA_W-1:0] data, rd_data;
    logic              status_q;

    mw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin_i({cs_i, sclk_i, di_i}), .lvl_o(pins_s)
    );
    assign {cs_s, sclk_s, di_s} = pins_s;

    mw_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
        .clk(clk), .rst(rst), .cs_i(cs_s), .sclk_i(sclk_s), .di_i(di_s),
        .busy_i(busy), .rd_data_i(rd_data), .start_o(start), .commit_o(commit),
        .cmd_o(cmd), .addr_o(addr), .data_o(data), .rd_addr_o(rd_addr),
        .reading_o(reading), .rd_bit_o(rd_bit)
    );

    mw_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_store (
        .clk(clk), .rst(rst), .commit_i(commit), .cmd_i(cmd), .addr_i(addr),
        .data_i(data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .busy_o(busy), .prog_start_o(prog_start)
    );

    always_ff @(posedge clk) begin
        if (rst)             status_q <= 1'b0;
        else if (prog_start) status_q <= 1'b1;
        else if (start)      status_q <= 1'b0;
    end

    always_comb begin
        do_oe_o = cs_s && (reading || status_q);
        do_o    = reading ? rd_bit : !busy;
    end

    // R6: entering the read phase shows the leading zero
    a_r6_dummy_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(reading) |-> (do_oe_o && !do_o));

    // R10: a running cycle always has its status armed
    a_r10_status_armed: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> status_q);
endmodule

// File: tb/tb_mw_eeprom_model.sv
module tb_mw_eeprom_model;
    localparam int PROG  = 150;
    localparam int HALF  = 6;
    localparam int DEPTH = 128;

    logic clk = 1'b0, rst = 1'b1, cs = 1'b0, sclk = 1'b0, di = 1'b0;
    logic do_w, oe_w;
    logic samp_do, samp_oe;
    logic [7:0] exp_mem [DEPTH];
    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    mw_eeprom_model #(.PROG_CYCLES(PROG)) dut (
        .clk(clk), .rst(rst), .cs_i(cs), .sclk_i(sclk), .di_i(di),
        .do_o(do_w), .do_oe_o(oe_w)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic hclk;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        di = b; hclk;
        sclk = 1'b1; hclk;
        samp_do = do_w; samp_oe = oe_w;
        sclk = 1'b0;
    endtask

    task automatic cs_up;
        cs = 1'b1; hclk;
    endtask

    task automatic cs_down;
        sclk = 1'b0; di = 1'b0; cs = 1'b0; hclk;
    endtask

    task automatic send_hdr(input logic [1:0] op, input logic [6:0] a);
        bit_out(1'b1);
        bit_out(op[1]); bit_out(op[0]);
        for (int i = 6; i >= 0; i--) bit_out(a[i]);
    endtask

    task automatic send_byte(input logic [7:0] d);
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
    endtask

    task automatic prog_op(input logic [1:0] op, input logic [6:0] a, input logic [7:0] d,
                           input bit with_data, input bit runs, input string req);
        cs_up;
        send_hdr(op, a);
        if (with_data) send_byte(d);
        cs_down;
        cs_up;
        if (runs) begin
            check(oe_w && !do_w, {req, " R10 busy"}, {oe_w, do_w}, 2'b10);
            cs_down;
            check(!oe_w, {req, " R11 cs low"}, oe_w, 0);
            repeat (PROG + 20) @(negedge clk);
            cs_up;
            check(oe_w && do_w, {req, " R10 ready"}, {oe_w, do_w}, 2'b11);
            bit_out(1'b1);
            check(!samp_oe, {req, " R11 cleared"}, samp_oe, 0);
        end else begin
            check(!oe_w, {req, " no status"}, oe_w, 0);
        end
        cs_down;
    endtask

    task automatic read_seq(input logic [6:0] a, input int nbytes, input int pre, input string req);
        logic [7:0] v, e;
        cs_up;
        for (int i = 0; i < pre; i++) bit_out(1'b0);
        send_hdr(2'b10, a);
        check(samp_oe && !samp_do, {req, " R6 dummy"}, {samp_oe, samp_do}, 2'b10);
        for (int b = 0; b < nbytes; b++) begin
            v = '0;
            for (int k = 0; k < 8; k++) begin
                bit_out(1'b0);
                v = {v[6:0], samp_do};
            end
            e = exp_mem[(int'(a) + b) % DEPTH];
            check(v == e, {req, " R6 data"}, v, e);
        end
        cs_down;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        summary;
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!oe_w, "R5 reset oe", oe_w, 0);
        read_seq(7'd5, 1, 0, "R5 reset contents");

        // locked write
        prog_op(2'b01, 7'd3, 8'h12, 1, 0, "R5 locked write");
        read_seq(7'd3, 1, 0, "R5 locked ignored");

        // unlock with don't-care bits
        prog_op(2'b00, 7'b11_01010, 8'h00, 0, 0, "R3 unlock");
        prog_op(2'b01, 7'd3, 8'h12, 1, 1, "R2 R8 write");
        exp_mem[3] = 8'h12;
        read_seq(7'd3, 1, 3, "R1 leading zeros R8");

        // instruction during busy
        cs_up; send_hdr(2'b01, 7'd4); send_byte(8'h34); cs_down;
        exp_mem[4] = 8'h34;
        cs_up; send_hdr(2'b11, 7'd4);
        check(samp_oe && !samp_do, "R12 still busy", {samp_oe, samp_do}, 2'b10);
        cs_down;
        repeat (PROG + 20) @(negedge clk);
        read_seq(7'd4, 1, 0, "R12 ignored while busy");

        // truncated frames
        cs_up; send_hdr(2'b01, 7'd3); bit_out(1); bit_out(0); bit_out(1); cs_down;
        cs_up; check(!oe_w, "R4 no status", oe_w, 0); cs_down;
        cs_up; bit_out(1); bit_out(1); bit_out(1); bit_out(0); bit_out(0); cs_down;
        cs_up; check(!oe_w, "R4 short header", oe_w, 0); cs_down;
        read_seq(7'd3, 2, 0, "R4 truncated dropped");

        // erase
        prog_op(2'b11, 7'd3, 8'h00, 0, 1, "R2 R8 erase");
        exp_mem[3] = 8'hFF;
        read_seq(7'd2, 3, 0, "R8 erase");

        // sweep of all addresses
        for (int a = 0; a < DEPTH; a++) begin
            logic [7:0] p;
            p = 8'((a * 29 + 7) & 8'hFF);
            prog_op(2'b01, 7'(a), p, 1, 1, "R8 sweep");
            exp_mem[a] = p;
        end
        read_seq(7'd0, DEPTH + 2, 0, "R7 stream wrap");
        read_seq(7'd120, 12, 0, "R7 wrap mid");

        // erase all
        prog_op(2'b00, 7'b10_00110, 8'h00, 0, 1, "R3 R9 erase all");
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
        read_seq(7'd0, DEPTH, 0, "R9 erase all");

        // write all
        prog_op(2'b00, 7'b01_11001, 8'hA5, 1, 1, "R3 R9 write all");
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hA5;
        read_seq(7'd0, DEPTH, 0, "R9 write all");

        // lock again
        prog_op(2'b00, 7'b00_10101, 8'h00, 0, 0, "R3 lock");
        prog_op(2'b01, 7'd9, 8'h3C, 1, 0, "R5 write after lock");
        prog_op(2'b11, 7'd10, 8'h00, 0, 0, "R5 erase after lock");
        read_seq(7'd9, 2, 0, "R5 relocked");

        summary;
        $finish;
    end
endmodule